// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer controlled through a single 32-bit control and status word on a simple register bus. The bus has a write strobe with write data and a read strobe with read data. Software picks a tick rate with a two-bit prescaler code and a timeout length with a two-bit interval code. Each code steps the time geometrically. Software then keeps the system alive by writing the restart bit again before the timeout runs out.

Expiry happens in two stages. First the interrupt flag is set, and the interrupt line rises if interrupts are enabled. This acts as an early warning. If software still does not restart the count, the block waits a fixed number of further ticks. It then drives a system reset pulse of fixed length and latches a sticky reset flag, but only when reset is enabled.

The `rst_n` input is the block's power-on reset. The reset pulse it drives out is not fed back into it, so the reset flag survives that pulse and can be read after the system reboots.

Top module: `wdog_timer`

## Requirements
- R1: The control word uses these bit positions: bit 0 restart, bit 1 reset enable, bit 2 reset flag, bit 3 interrupt flag, bits 5:4 interval code, bit 6 interrupt enable, bit 7 watchdog enable, bits 11:10 prescaler code. All other bits read as 0. The restart bit always reads 0. After `rst_n`, the whole word reads 0.
- R2: The tick period is 2^PRE_BASE_LOG2 clocks times 1, 8, 64 or 2048 for prescaler codes 00, 01, 10 and 11.
- R3: The interval code n sets the first-stage timeout to 2^(IVL_BASE_LOG2+2n) ticks. With prescaler period P, the interrupt flag is first read as 1 exactly T = ticks×P clock edges after the edge that accepted a write with restart and enable set. At T−1 edges it still reads 0.
- R4: A write with bit 0 set zeroes the tick and interval counts. All other fields take their values from the same word, so rewriting the current word with bit 0 set works as a keep-alive.
- R5: `irq_out` is high exactly when the interrupt flag, interrupt enable and watchdog enable are all 1.
- R6: Writing 1 to bit 3 clears the interrupt flag, and writing 1 to bit 2 clears the reset flag. Writing 0 to either bit leaves it unchanged.
- R7: With reset enable set, `rst_out` rises WARN_TICKS ticks after the interrupt flag was set, unless the count is restarted first. The reset flag is set at the same edge.
- R8: Each reset pulse lasts exactly RST_PULSE_CLKS clocks.
- R9: With reset enable clear, no reset pulse is issued and the reset flag stays 0.
- R10: The reset flag stays set through and after its own reset pulse, until software clears it.
- R11: While the watchdog enable is 0, the counts are held at zero and no flag, interrupt or reset is produced.
- R12: A restart written during the warning stage cancels the pending reset. The next reset then comes a full T + WARN_TICKS×P clocks after that restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe; read data is driven combinationally while it is high |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data; 0 while `rd_en` is low |
| irq_out | output | 1 | Pre-timeout interrupt |
| rst_out | output | 1 | System reset pulse, active high |

## Verification
Every result is timed from the clock edge that accepts a write with restart set. The interrupt flag becomes readable T edges later. The reset rises WARN_TICKS×P edges after that and falls RST_PULSE_CLKS edges after rising. Reads are combinational, so a flag is visible in the same half cycle it is sampled. The bench drives and samples only on the falling clock edge and counts whole clock periods from the accepting edge. For each expected edge it checks one edge before, to confirm the output has not moved, and then at the edge itself. Where an event must not happen, such as a disabled reset or a cancelled reset, the bench samples `rst_out` every cycle over a window that covers the instant the event would have occurred.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BIT_RESTART  = 0;
  localparam int BIT_RST_EN   = 1;
  localparam int BIT_RST_FLAG = 2;
  localparam int BIT_IRQ_FLAG = 3;
  localparam int BIT_IVL_LO   = 4;
  localparam int BIT_IRQ_EN   = 6;
  localparam int BIT_EN       = 7;
  localparam int BIT_PRE_LO   = 10;

  typedef struct packed {
    logic [1:0] pre_sel;
    logic       en;
    logic       irq_en;
    logic [1:0] ivl_sel;
    logic       rst_en;
  } wdog_ctl_t;

  typedef enum logic {PH_COUNT = 1'b0, PH_WARN = 1'b1} wdog_phase_e;

  // log2 of the tick period multiplier for a prescaler code
  function automatic int unsigned pre_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 3;
      2'd2:    return 6;
      default: return 11;
    endcase
  endfunction

  // log2 of the timeout multiplier for an interval code
  function automatic int unsigned ivl_shift(input logic [1:0] sel);
    return 2 * int'(sel);
  endfunction

  function automatic logic [31:0] pack_word(input wdog_ctl_t c,
                                            input logic irq_f,
                                            input logic rst_f);
    logic [31:0] w;
    w = '0;
    w[BIT_RST_EN]        = c.rst_en;
    w[BIT_RST_FLAG]      = rst_f;
    w[BIT_IRQ_FLAG]      = irq_f;
    w[BIT_IVL_LO +: 2]   = c.ivl_sel;
    w[BIT_IRQ_EN]        = c.irq_en;
    w[BIT_EN]            = c.en;
    w[BIT_PRE_LO +: 2]   = c.pre_sel;
    return w;
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen import wdog_pkg::*; #(
  parameter int PRE_BASE_LOG2 = 0,
  localparam int PW = PRE_BASE_LOG2 + 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] pre_sel,
  output logic       tick
);
  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] pre_limit;

  assign pre_limit = (PW'(1) << (PRE_BASE_LOG2 + pre_shift(pre_sel))) - PW'(1);
  assign tick = run && !clear && (pre_cnt >= pre_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (!run || clear)  pre_cnt <= '0;
    else if (tick)           pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + PW'(1);
  end

  // R2: a clear always leaves the prescaler at zero
  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_cnt == '0));
endmodule

// File: rtl/wdog_interval_ctr.sv
module wdog_interval_ctr import wdog_pkg::*; #(
  parameter int IVL_BASE_LOG2 = 4,
  parameter int WARN_TICKS    = 1024,
  localparam int CW_A = IVL_BASE_LOG2 + 7,
  localparam int CW_B = $clog2(WARN_TICKS) + 1,
  localparam int CW   = (CW_A > CW_B) ? CW_A : CW_B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] ivl_sel,
  output logic       expire_evt,
  output logic       warn_done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_limit;
  wdog_phase_e   phase;
  logic          at_limit;

  always_comb begin
    if (phase == PH_COUNT)
      cnt_limit = (CW'(1) << (IVL_BASE_LOG2 + ivl_shift(ivl_sel))) - CW'(1);
    else
      cnt_limit = CW'(WARN_TICKS - 1);
  end

  assign at_limit   = run && !restart && tick && (cnt >= cnt_limit);
  assign expire_evt = at_limit && (phase == PH_COUNT);
  assign warn_done  = at_limit && (phase == PH_WARN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_COUNT;
    end else if (!run || restart) begin
      cnt   <= '0;
      phase <= PH_COUNT;
    end else if (tick) begin
      if (at_limit) begin
        cnt   <= '0;
        phase <= (phase == PH_COUNT) ? PH_WARN : PH_COUNT;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R4: restart returns the count to the start of the first stage
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && phase == PH_COUNT));
  // R12: the warning stage is always entered through a first-stage expiry
  assert_warn_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WARN && $past(phase) == PH_COUNT) |-> $past(expire_evt));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_PULSE_CLKS = 16,
  localparam int PCW = $clog2(RST_PULSE_CLKS) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rst_out
);
  logic           busy;
  logic [PCW-1:0] len_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      len_cnt <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      len_cnt <= '0;
    end else if (busy) begin
      if (len_cnt == PCW'(RST_PULSE_CLKS - 1)) busy <= 1'b0;
      else                                      len_cnt <= len_cnt + PCW'(1);
    end
  end

  assign rst_out = busy;

  // R8: the pulse ends only after its full length
  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> ($past(len_cnt) == PCW'(RST_PULSE_CLKS - 1)));
  // R8: a new request never lands on a pulse in progress
  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
  parameter int PRE_BASE_LOG2  = 0,
  parameter int IVL_BASE_LOG2  = 4,
  parameter int WARN_TICKS     = 1024,
  parameter int RST_PULSE_CLKS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq_out,
  output logic        rst_out
);
  wdog_ctl_t ctl;
  logic      irq_flag;
  logic      rst_flag;
  logic      restart;
  logic      tick;
  logic      expire_evt;
  logic      warn_done;
  logic      fire_rst;
  logic      clr_irq;
  logic      clr_rst;
  logic      unused_wr_bits;

  assign restart  = wr_en && wr_data[BIT_RESTART];
  assign clr_irq  = wr_en && wr_data[BIT_IRQ_FLAG];
  assign clr_rst  = wr_en && wr_data[BIT_RST_FLAG];
  assign fire_rst = warn_done && ctl.rst_en;
  assign unused_wr_bits = ^{wr_data[31:12], wr_data[9:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.rst_en  <= wr_data[BIT_RST_EN];
      ctl.ivl_sel <= wr_data[BIT_IVL_LO +: 2];
      ctl.irq_en  <= wr_data[BIT_IRQ_EN];
      ctl.en      <= wr_data[BIT_EN];
      ctl.pre_sel <= wr_data[BIT_PRE_LO +: 2];
    end
  end

  // flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rst_flag <= 1'b0;
    end else begin
      irq_flag <= expire_evt || (irq_flag && !clr_irq);
      rst_flag <= fire_rst   || (rst_flag && !clr_rst);
    end
  end

  wdog_tick_gen #(.PRE_BASE_LOG2(PRE_BASE_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctl.en), .clear(restart),
    .pre_sel(ctl.pre_sel), .tick(tick)
  );

  wdog_interval_ctr #(.IVL_BASE_LOG2(IVL_BASE_LOG2), .WARN_TICKS(WARN_TICKS)) u_ivl (
    .clk(clk), .rst_n(rst_n), .run(ctl.en), .restart(restart), .tick(tick),
    .ivl_sel(ctl.ivl_sel), .expire_evt(expire_evt), .warn_done(warn_done)
  );

  wdog_rst_pulse #(.RST_PULSE_CLKS(RST_PULSE_CLKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_rst), .rst_out(rst_out)
  );

  assign irq_out = irq_flag && ctl.irq_en && ctl.en;
  assign rd_data = rd_en ? pack_word(ctl, irq_flag, rst_flag) : 32'h0;

  // R3: a first-stage expiry always leaves the interrupt flag set
  assert_flag_on_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> irq_flag);
  // R9: a reset pulse only starts when reset enable was set
  assert_reset_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(ctl.rst_en));
  // R10: the reset flag only drops on a software clear
  assert_rstflag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !clr_rst) |=> rst_flag);
  // R11: no expiry while the watchdog is off
  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> !(expire_evt || warn_done));
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WARN = 1024;
  localparam int PULSE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;
  logic        rst_out;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out), .rst_out(rst_out)
  );

  function automatic logic [31:0] cw(input int pre, input bit en, input bit irq_en,
                                     input int ivl, input bit rst_en, input bit restart);
    logic [31:0] w;
    w = '0;
    w[11:10] = pre[1:0];
    w[7] = en;
    w[6] = irq_en;
    w[5:4] = ivl[1:0];
    w[1] = rst_en;
    w[0] = restart;
    return w;
  endfunction

  function automatic int period(input int pre);
    int p [4] = '{1, 8, 64, 2048};
    return p[pre];
  endfunction

  function automatic int first_stage(input int pre, input int ivl);
    return (16 * (4 ** ivl)) * period(pre);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    rd_en = 1'b1; #1; d = rd_data; rd_en = 1'b0;
  endtask

  task automatic quiesce();
    wait_edges(PULSE + 2);
    wr(32'h0000_000C);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(d);
    chk("R1 reset word", d, 32'h0);
    chk("R1 reset irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 reset rst_out", {31'b0, rst_out}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(cw(2, 1, 1, 3, 1, 1));
    rd(d);
    chk("R1 field readback, restart reads 0", d, 32'h0000_08F2);
    quiesce();
  endtask

  task automatic t_timeout(input int pre, input int ivl);
    logic [31:0] d;
    int t;
    t = first_stage(pre, ivl);
    wr(cw(pre, 1, 1, ivl, 0, 1));
    wait_edges(t - 1);
    rd(d);
    chk("R2 R3 flag before timeout", {31'b0, d[3]}, 32'h0);
    wait_edges(1);
    rd(d);
    chk("R2 R3 flag at timeout", {31'b0, d[3]}, 32'h1);
    chk("R5 irq_out at timeout", {31'b0, irq_out}, 32'h1);
    quiesce();
  endtask

  task automatic t_keepalive();
    logic [31:0] d;
    wr(cw(0, 1, 1, 0, 0, 1));
    wait_edges(10);
    wr(cw(0, 1, 1, 1, 0, 1));
    wait_edges(63);
    rd(d);
    chk("R4 keep-alive no flag yet", {31'b0, d[3]}, 32'h0);
    wait_edges(1);
    rd(d);
    chk("R4 new interval applied", {31'b0, d[3]}, 32'h1);
    quiesce();
  endtask

  task automatic t_irq_gating_and_clear();
    logic [31:0] d;
    wr(cw(0, 1, 0, 0, 0, 1));
    wait_edges(16);
    rd(d);
    chk("R5 flag set with irq disabled", {31'b0, d[3]}, 32'h1);
    chk("R5 irq_out low with irq disabled", {31'b0, irq_out}, 32'h0);
    wr(cw(0, 1, 1, 0, 0, 0));
    chk("R5 irq_out follows enable", {31'b0, irq_out}, 32'h1);
    wr(cw(0, 0, 1, 0, 0, 0));
    chk("R11 irq_out low when watchdog off", {31'b0, irq_out}, 32'h0);
    rd(d);
    chk("R6 writing 0 keeps flag", {31'b0, d[3]}, 32'h1);
    wr(cw(0, 1, 1, 0, 0, 0) | 32'h8);
    rd(d);
    chk("R6 write 1 clears irq flag", {31'b0, d[3]}, 32'h0);
    chk("R6 irq_out drops after clear", {31'b0, irq_out}, 32'h0);
    quiesce();
  endtask

  task automatic t_reset_path();
    logic [31:0] d;
    wr(cw(0, 1, 0, 0, 1, 1));
    wait_edges(16 + WARN - 1);
    chk("R7 no reset one edge early", {31'b0, rst_out}, 32'h0);
    wait_edges(1);
    chk("R7 reset rises", {31'b0, rst_out}, 32'h1);
    rd(d);
    chk("R7 reset flag set", {31'b0, d[2]}, 32'h1);
    wait_edges(PULSE - 1);
    chk("R8 reset still high at last cycle", {31'b0, rst_out}, 32'h1);
    wait_edges(1);
    chk("R8 reset ends after pulse", {31'b0, rst_out}, 32'h0);
    rd(d);
    chk("R10 reset flag survives pulse", {31'b0, d[2]}, 32'h1);
    wr(32'h0000_0004);
    rd(d);
    chk("R6 write 1 clears reset flag", {31'b0, d[2]}, 32'h0);
    quiesce();
  endtask

  task automatic t_no_reset_enable();
    logic [31:0] d;
    bit seen = 1'b0;
    wr(cw(0, 1, 0, 0, 0, 1));
    for (int i = 0; i < 16 + WARN + 40; i++) begin
      wait_edges(1);
      if (rst_out) seen = 1'b1;
    end
    chk("R9 no pulse with reset disabled", {31'b0, seen}, 32'h0);
    rd(d);
    chk("R9 reset flag stays 0", {31'b0, d[2]}, 32'h0);
    quiesce();
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    bit seen = 1'b0;
    wr(cw(0, 1, 1, 0, 1, 1));
    wait_edges(10);
    wr(32'h0);
    for (int i = 0; i < 2 * (16 + WARN); i++) begin
      wait_edges(1);
      if (rst_out || irq_out) seen = 1'b1;
    end
    rd(d);
    chk("R11 stopped: no irq or reset", {31'b0, seen}, 32'h0);
    chk("R11 stopped: flags clear, enable reads 0", d, 32'h0);
  endtask

  task automatic t_cancel_in_warn();
    bit seen = 1'b0;
    wr(cw(0, 1, 0, 0, 1, 1));
    wait_edges(500);
    wr(cw(0, 1, 0, 0, 1, 1));
    for (int i = 0; i < 16 + WARN - 1; i++) begin
      wait_edges(1);
      if (rst_out) seen = 1'b1;
    end
    chk("R12 restart in warning cancels reset", {31'b0, seen}, 32'h0);
    wait_edges(1);
    chk("R12 reset after full period from restart", {31'b0, rst_out}, 32'h1);
    quiesce();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_readback();
    t_timeout(0, 0);
    t_timeout(1, 0);
    t_timeout(2, 0);
    t_timeout(3, 0);
    t_timeout(0, 1);
    t_timeout(0, 2);
    t_timeout(0, 3);
    t_keepalive();
    t_irq_gating_and_clear();
    t_reset_path();
    t_no_reset_enable();
    t_disabled();
    t_cancel_in_warn();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule